// File: doc/BRIEF.md
# Streaming Store Merge Pool

This block collects weakly ordered streaming stores into a small pool of line buffers. Each line buffer covers one 64-byte aligned region and records which of its bytes have been written. Stores that fall into a region that already has a buffer are merged into that buffer. A buffer whose 64 bytes have all been written leaves at once as a single burst with a full byte mask. A buffer that is only partly written leaves with its partial mask in two cases: its slot is needed for a new region, or a fence drains the pool. Between the pool and memory there is only one burst port with a valid/ready handshake. The block never reads a line before it writes it.

A store carries a byte address, a size code, up to 32 bytes of data and one enable bit per byte. It must be naturally aligned. A store that is not aligned is accepted and thrown away, and the error flag is raised. A fence request stops new stores, drains every buffer oldest first and ends with a one-cycle completion pulse. The control FSM has three states. RUN accepts stores. RUN moves to DRAIN when a fence is seen (transition "fence seen"). DRAIN moves to DONE once the pool and the output register are empty (transition "drained"). DONE returns to RUN one cycle later (transition "acknowledge").

Top module: `msp_pool`

## Requirements
- R1: After reset, wr_valid, fence_done and st_err are 0. st_ready is 1 while no fence is requested.
- R2: Stores whose addresses share bits [31:6] merge into one buffer, and that buffer leaves the pool as exactly one burst.
- R3: When a merge sets the last unwritten byte of a buffer, the buffer is sent as one burst with wr_mask all ones. No fence is needed for this.
- R4: A partly written buffer is sent only on eviction or on a fence. Its wr_mask bit j is set exactly when line byte j was written, and each written byte carries the value of the latest store to it. Bytes whose mask bit is clear are unspecified.
- R5: A store to a new region when all NUM_BUF buffers are in use evicts the buffer allocated longest ago. That buffer is sent with its mask, and the new store takes over its slot.
- R6: While fence_req is high, the block sends every buffer oldest-allocated first. It then raises fence_done for exactly one cycle, after the last burst has been accepted and while wr_valid is 0.
- R7: st_ready stays 0 from the cycle fence_req is high until fence_done has been pulsed.
- R8: A store that is not naturally aligned, or that has size code 3, is accepted. st_err is 1 in the next cycle, and the store changes no buffer.
- R9: While wr_valid is 1 and wr_ready is 0, wr_valid, wr_addr, wr_mask and wr_data hold their values.
- R10: Size codes 0, 1 and 2 select 8, 16 and 32 bytes. Store byte k is st_data[8k+7:8k], enabled by st_be[k], and lands at line byte st_addr[5:0]+k. Line byte j is wr_data[8j+7:8j]. wr_addr is the line address with bits [5:0] zero.
- R11: A fence on an empty pool completes with fence_done and sends no burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store request valid |
| st_ready | output | 1 | Store accepted when high with st_valid |
| st_addr | input | ADDR_W | Store byte address |
| st_size | input | 2 | Size code: 0=8, 1=16, 2=32 bytes |
| st_be | input | STORE_BYTES | Per-byte enables of the store |
| st_data | input | 8*STORE_BYTES | Store data, byte k at bits 8k+7:8k |
| st_err | output | 1 | One-cycle flag for a rejected store |
| fence_req | input | 1 | Fence request, held until fence_done |
| fence_done | output | 1 | One-cycle fence completion pulse |
| wr_valid | output | 1 | Burst valid |
| wr_ready | input | 1 | Burst accepted when high with wr_valid |
| wr_addr | output | ADDR_W | Line address of the burst |
| wr_data | output | 8*LINE_BYTES | Line data |
| wr_mask | output | LINE_BYTES | Written-byte mask of the line |

## Verification
A wrong age rank shows up at the ports on the next eviction or fence: the burst that comes out carries the address of the wrong line. A corrupt mask or a bad merge shows up in the mask or the data bytes of the burst that carries that line. A buffer that never registers as full shows up as a missing burst a few cycles after the filling store. A free flag that goes missing shows up as a burst that was never expected, or as fence_done arriving while writes are still owed. The bench models the buffers from the requirements and compares every burst in order. Random backpressure is applied on wr_ready throughout.

// File: rtl/msp_pkg.sv
`timescale 1ns/1ps
package msp_pkg;
    typedef enum logic [1:0] {
        S_RUN   = 2'd0,
        S_DRAIN = 2'd1,
        S_DONE  = 2'd2
    } msp_state_e;
endpackage

// File: rtl/msp_align.sv
`timescale 1ns/1ps
// Decodes a store: checks natural alignment and places bytes and enables at their line offset.
module msp_align #(
    parameter int ADDR_W      = 32,
    parameter int LINE_BYTES  = 64,
    parameter int STORE_BYTES = 32,
    parameter int MIN_BYTES   = 8,
    localparam int OFF_W      = $clog2(LINE_BYTES),
    localparam int TAG_W      = ADDR_W - OFF_W,
    localparam int LINE_BITS  = LINE_BYTES * 8
) (
    input  logic [ADDR_W-1:0]        addr,
    input  logic [1:0]               size,
    input  logic [STORE_BYTES-1:0]   be,
    input  logic [STORE_BYTES*8-1:0] data,
    output logic                     bad,
    output logic [TAG_W-1:0]         tag,
    output logic [LINE_BYTES-1:0]    line_be,
    output logic [LINE_BITS-1:0]     line_data
);
    localparam int MAX_CODE = $clog2(STORE_BYTES / MIN_BYTES);

    logic [OFF_W-1:0]       off;
    logic [OFF_W:0]         nbytes;
    logic [STORE_BYTES-1:0] be_m;

    always_comb begin
        off    = addr[OFF_W-1:0];
        nbytes = (OFF_W+1)'(MIN_BYTES) << size;
        for (int k = 0; k < STORE_BYTES; k++) begin
            be_m[k] = be[k] && ((OFF_W+1)'(k) < nbytes);
        end
        bad       = (int'(size) > MAX_CODE) ||
                    ((off & (nbytes[OFF_W-1:0] - 1'b1)) != '0);
        tag       = addr[ADDR_W-1:OFF_W];
        line_be   = LINE_BYTES'(be_m) << off;
        line_data = LINE_BITS'(data) << {off, 3'b000};
    end
endmodule

// File: rtl/msp_slot.sv
`timescale 1ns/1ps
// One line buffer: tag, byte mask, data and an age rank among the occupied slots.
module msp_slot #(
    parameter int TAG_W      = 26,
    parameter int LINE_BYTES = 64,
    parameter int AGE_W      = 2,
    localparam int LINE_BITS = LINE_BYTES * 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  alloc,
    input  logic                  merge,
    input  logic                  rel,
    input  logic                  inc,
    input  logic                  dec,
    input  logic [TAG_W-1:0]      tag_in,
    input  logic [LINE_BYTES-1:0] be_in,
    input  logic [LINE_BITS-1:0]  data_in,
    output logic                  valid,
    output logic                  hit,
    output logic [AGE_W-1:0]      age,
    output logic [TAG_W-1:0]      tag,
    output logic [LINE_BYTES-1:0] mask,
    output logic [LINE_BITS-1:0]  data,
    output logic [LINE_BYTES-1:0] mrg_mask,
    output logic [LINE_BITS-1:0]  mrg_data
);
    always_comb begin
        hit      = valid && (tag == tag_in);
        mrg_mask = mask | be_in;
        for (int j = 0; j < LINE_BYTES; j++) begin
            mrg_data[j*8 +: 8] = be_in[j] ? data_in[j*8 +: 8] : data[j*8 +: 8];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
            age   <= '0;
            tag   <= '0;
            mask  <= '0;
            data  <= '0;
        end else begin
            if (alloc) begin
                valid <= 1'b1;
                tag   <= tag_in;
                mask  <= be_in;
                data  <= mrg_data;
                age   <= '0;
            end else begin
                if (rel) begin
                    valid <= 1'b0;
                    mask  <= '0;
                end else if (merge) begin
                    mask <= mrg_mask;
                    data <= mrg_data;
                end
                if (inc)      age <= age + 1'b1;
                else if (dec) age <= age - 1'b1;
            end
        end
    end
endmodule

// File: rtl/msp_pick.sv
`timescale 1ns/1ps
// Selection logic: lowest free slot, oldest occupied slot, matching slot.
module msp_pick #(
    parameter int NUM_BUF = 4,
    parameter int AGE_W   = 2,
    parameter int IDX_W   = 2
) (
    input  logic [NUM_BUF-1:0]            valid,
    input  logic [NUM_BUF-1:0]            hit,
    input  logic [NUM_BUF-1:0][AGE_W-1:0] age,
    output logic                          any_valid,
    output logic                          free_any,
    output logic [IDX_W-1:0]              free_idx,
    output logic [IDX_W-1:0]              old_idx,
    output logic                          hit_any,
    output logic [IDX_W-1:0]              hit_idx
);
    logic [AGE_W-1:0] best;

    always_comb begin
        any_valid = |valid;
        hit_any   = |hit;
        free_any  = 1'b0;
        free_idx  = '0;
        hit_idx   = '0;
        old_idx   = '0;
        best      = '0;
        for (int i = NUM_BUF-1; i >= 0; i--) begin
            if (!valid[i]) begin
                free_any = 1'b1;
                free_idx = IDX_W'(i);
            end
            if (hit[i]) hit_idx = IDX_W'(i);
        end
        for (int i = 0; i < NUM_BUF; i++) begin
            if (valid[i] && age[i] >= best) begin
                best    = age[i];
                old_idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/msp_pool.sv
`timescale 1ns/1ps
// Pool of line buffers merging streaming stores into line bursts.
module msp_pool
    import msp_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int LINE_BYTES  = 64,
    parameter int STORE_BYTES = 32,
    parameter int NUM_BUF     = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      st_valid,
    output logic                      st_ready,
    input  logic [ADDR_W-1:0]         st_addr,
    input  logic [1:0]                st_size,
    input  logic [STORE_BYTES-1:0]    st_be,
    input  logic [STORE_BYTES*8-1:0]  st_data,
    output logic                      st_err,
    input  logic                      fence_req,
    output logic                      fence_done,
    output logic                      wr_valid,
    input  logic                      wr_ready,
    output logic [ADDR_W-1:0]         wr_addr,
    output logic [LINE_BYTES*8-1:0]   wr_data,
    output logic [LINE_BYTES-1:0]     wr_mask
);
    localparam int LINE_BITS = LINE_BYTES * 8;
    localparam int OFF_W     = $clog2(LINE_BYTES);
    localparam int TAG_W     = ADDR_W - OFF_W;
    localparam int IDX_W     = $clog2(NUM_BUF);
    localparam int AGE_W     = IDX_W;

    msp_state_e state, nxt;

    logic                  bad;
    logic [TAG_W-1:0]      in_tag;
    logic [LINE_BYTES-1:0] in_be;
    logic [LINE_BITS-1:0]  in_data;

    logic [NUM_BUF-1:0]                 e_valid, e_hit;
    logic [NUM_BUF-1:0]                 e_alloc, e_merge, e_rel, e_inc, e_dec;
    logic [NUM_BUF-1:0][AGE_W-1:0]      e_age;
    logic [NUM_BUF-1:0][TAG_W-1:0]      e_tag;
    logic [NUM_BUF-1:0][LINE_BYTES-1:0] e_mask, e_mrg_mask;
    logic [NUM_BUF-1:0][LINE_BITS-1:0]  e_data, e_mrg_data;

    logic             any_valid, free_any, hit_any;
    logic [IDX_W-1:0] free_idx, old_idx, hit_idx;

    logic                  ob_valid, ob_load, ob_free, err_set;
    logic [TAG_W-1:0]      ob_tag, ob_tag_n;
    logic [LINE_BYTES-1:0] ob_mask, ob_mask_n;
    logic [LINE_BITS-1:0]  ob_data, ob_data_n;

    msp_align #(
        .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .STORE_BYTES(STORE_BYTES), .MIN_BYTES(8)
    ) u_align (
        .addr(st_addr), .size(st_size), .be(st_be), .data(st_data),
        .bad(bad), .tag(in_tag), .line_be(in_be), .line_data(in_data)
    );

    for (genvar g = 0; g < NUM_BUF; g++) begin : g_slot
        msp_slot #(
            .TAG_W(TAG_W), .LINE_BYTES(LINE_BYTES), .AGE_W(AGE_W)
        ) u_slot (
            .clk(clk), .rst_n(rst_n),
            .alloc(e_alloc[g]), .merge(e_merge[g]), .rel(e_rel[g]),
            .inc(e_inc[g]), .dec(e_dec[g]),
            .tag_in(in_tag), .be_in(in_be), .data_in(in_data),
            .valid(e_valid[g]), .hit(e_hit[g]), .age(e_age[g]),
            .tag(e_tag[g]), .mask(e_mask[g]), .data(e_data[g]),
            .mrg_mask(e_mrg_mask[g]), .mrg_data(e_mrg_data[g])
        );
    end

    msp_pick #(
        .NUM_BUF(NUM_BUF), .AGE_W(AGE_W), .IDX_W(IDX_W)
    ) u_pick (
        .valid(e_valid), .hit(e_hit), .age(e_age),
        .any_valid(any_valid), .free_any(free_any), .free_idx(free_idx),
        .old_idx(old_idx), .hit_any(hit_any), .hit_idx(hit_idx)
    );

    assign ob_free = !ob_valid || wr_ready;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_RUN;
        else        state <= nxt;
    end

    // Next state, slot controls and outputs
    always_comb begin
        nxt        = state;
        e_alloc    = '0;
        e_merge    = '0;
        e_rel      = '0;
        e_inc      = '0;
        e_dec      = '0;
        ob_load    = 1'b0;
        ob_tag_n   = '0;
        ob_mask_n  = '0;
        ob_data_n  = '0;
        err_set    = 1'b0;
        st_ready   = 1'b0;
        fence_done = 1'b0;
        unique case (state)
            S_RUN: begin
                st_ready = !fence_req && ob_free;
                if (fence_req) begin
                    nxt = S_DRAIN;
                end else if (st_valid && ob_free) begin
                    if (bad) begin
                        err_set = 1'b1;
                    end else if (hit_any) begin
                        if (&e_mrg_mask[hit_idx]) begin
                            e_rel[hit_idx] = 1'b1;
                            ob_load   = 1'b1;
                            ob_tag_n  = e_tag[hit_idx];
                            ob_mask_n = e_mrg_mask[hit_idx];
                            ob_data_n = e_mrg_data[hit_idx];
                            for (int i = 0; i < NUM_BUF; i++) begin
                                e_dec[i] = e_valid[i] && (e_age[i] > e_age[hit_idx]);
                            end
                        end else begin
                            e_merge[hit_idx] = 1'b1;
                        end
                    end else if (free_any) begin
                        e_alloc[free_idx] = 1'b1;
                        e_inc = e_valid;
                    end else begin
                        ob_load   = 1'b1;
                        ob_tag_n  = e_tag[old_idx];
                        ob_mask_n = e_mask[old_idx];
                        ob_data_n = e_data[old_idx];
                        e_alloc[old_idx] = 1'b1;
                        for (int i = 0; i < NUM_BUF; i++) begin
                            e_inc[i] = e_valid[i] && (IDX_W'(i) != old_idx);
                        end
                    end
                end
            end
            S_DRAIN: begin
                if (ob_free) begin
                    if (any_valid) begin
                        e_rel[old_idx] = 1'b1;
                        ob_load   = 1'b1;
                        ob_tag_n  = e_tag[old_idx];
                        ob_mask_n = e_mask[old_idx];
                        ob_data_n = e_data[old_idx];
                    end else begin
                        nxt = S_DONE;
                    end
                end
            end
            S_DONE: begin
                fence_done = 1'b1;
                nxt        = S_RUN;
            end
            default: nxt = S_RUN;
        endcase
    end

    // Output burst register and error flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ob_valid <= 1'b0;
            ob_tag   <= '0;
            ob_mask  <= '0;
            ob_data  <= '0;
            st_err   <= 1'b0;
        end else begin
            st_err <= err_set;
            if (ob_load) begin
                ob_valid <= 1'b1;
                ob_tag   <= ob_tag_n;
                ob_mask  <= ob_mask_n;
                ob_data  <= ob_data_n;
            end else if (wr_ready) begin
                ob_valid <= 1'b0;
            end
        end
    end

    assign wr_valid = ob_valid;
    assign wr_addr  = {ob_tag, {OFF_W{1'b0}}};
    assign wr_mask  = ob_mask;
    assign wr_data  = ob_data;
endmodule

// File: rtl/msp_pool_chk.sv
`timescale 1ns/1ps
module msp_pool_chk #(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 64
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    st_valid,
    input logic                    st_ready,
    input logic                    st_err,
    input logic                    fence_req,
    input logic                    fence_done,
    input logic                    wr_valid,
    input logic                    wr_ready,
    input logic [ADDR_W-1:0]       wr_addr,
    input logic [LINE_BYTES-1:0]   wr_mask,
    input logic [LINE_BYTES*8-1:0] wr_data
);
    // R9
    burst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_mask) && $stable(wr_data)));

    // R8
    err_needs_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_err |-> $past(st_valid && st_ready));

    // R7
    fence_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fence_req |-> !st_ready);

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fence_done |=> !fence_done);

    // R6
    done_drained_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fence_done |-> !wr_valid);

    // R6
    done_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fence_done |-> $past(fence_req));
endmodule

bind msp_pool msp_pool_chk #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) u_chk (
    .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_ready(st_ready),
    .st_err(st_err), .fence_req(fence_req), .fence_done(fence_done),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
    .wr_mask(wr_mask), .wr_data(wr_data)
);

// File: tb/msp_pool_test.sv
`timescale 1ns/1ps
module msp_pool_test;
    logic         clk = 1'b0;
    logic         rst_n;
    logic         st_valid, st_ready, st_err;
    logic [31:0]  st_addr;
    logic [1:0]   st_size;
    logic [31:0]  st_be;
    logic [255:0] st_data;
    logic         fence_req, fence_done;
    logic         wr_valid, wr_ready;
    logic [31:0]  wr_addr;
    logic [511:0] wr_data;
    logic [63:0]  wr_mask;

    always #10 clk = ~clk;

    msp_pool uut (
        .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_ready(st_ready),
        .st_addr(st_addr), .st_size(st_size), .st_be(st_be), .st_data(st_data),
        .st_err(st_err), .fence_req(fence_req), .fence_done(fence_done),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_mask(wr_mask)
    );

    int checks = 0;
    int errors = 0;
    int obs_cnt = 0;
    bit bp_on = 1'b0;

    // Model of the pool
    logic         m_valid [4];
    logic [25:0]  m_tag   [4];
    logic [511:0] m_data  [4];
    logic [63:0]  m_mask  [4];
    int           m_seq   [4];
    int           seq_ctr = 0;

    logic [31:0]  q_addr [512];
    logic [511:0] q_data [512];
    logic [63:0]  q_mask [512];
    int q_head = 0;
    int q_tail = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [511:0] act, input logic [511:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [511:0] expand(input logic [63:0] m);
        logic [511:0] r;
        for (int j = 0; j < 64; j++) r[j*8 +: 8] = {8{m[j]}};
        return r;
    endfunction

    task automatic push(input int i);
        if (q_tail < 512) begin
            q_addr[q_tail] = {m_tag[i], 6'b0};
            q_data[q_tail] = m_data[i];
            q_mask[q_tail] = m_mask[i];
            q_tail++;
        end
        m_valid[i] = 1'b0;
    endtask

    function automatic int oldest();
        int o = -1;
        for (int i = 0; i < 4; i++)
            if (m_valid[i] && (o < 0 || m_seq[i] < m_seq[o])) o = i;
        return o;
    endfunction

    function automatic bit is_bad(input logic [31:0] a, input logic [1:0] sz);
        int nb = 8 << sz;
        if (sz == 2'd3) return 1'b1;
        return (a[5:0] % nb) != 0;
    endfunction

    task automatic model_store(input logic [31:0] a, input logic [1:0] sz,
                               input logic [31:0] be, input logic [255:0] d);
        logic [63:0]  lbe = '0;
        logic [511:0] ld  = '0;
        int nb = 8 << sz;
        int off = int'(a[5:0]);
        int h = -1;
        int f = -1;
        for (int k = 0; k < nb; k++) begin
            if (be[k]) begin
                lbe[off+k] = 1'b1;
                ld[(off+k)*8 +: 8] = d[k*8 +: 8];
            end
        end
        for (int i = 0; i < 4; i++) if (m_valid[i] && m_tag[i] == a[31:6]) h = i;
        if (h >= 0) begin
            for (int j = 0; j < 64; j++)
                if (lbe[j]) m_data[h][j*8 +: 8] = ld[j*8 +: 8];
            m_mask[h] = m_mask[h] | lbe;
            if (&m_mask[h]) push(h);
        end else begin
            for (int i = 3; i >= 0; i--) if (!m_valid[i]) f = i;
            if (f < 0) begin
                f = oldest();
                push(f);
            end
            m_valid[f] = 1'b1;
            m_tag[f]   = a[31:6];
            m_mask[f]  = lbe;
            m_data[f]  = ld;
            m_seq[f]   = seq_ctr;
            seq_ctr++;
        end
    endtask

    task automatic model_fence();
        int o = oldest();
        while (o >= 0) begin
            push(o);
            o = oldest();
        end
    endtask

    task automatic do_store(input logic [31:0] a, input logic [1:0] sz,
                            input logic [31:0] be, input logic [255:0] d);
        bit exp_bad;
        @(negedge clk);
        st_valid = 1'b1;
        st_addr = a;
        st_size = sz;
        st_be = be;
        st_data = d;
        #1;
        while (!st_ready) begin
            @(negedge clk);
            #1;
        end
        exp_bad = is_bad(a, sz);
        if (!exp_bad) model_store(a, sz, be, d);
        @(negedge clk);
        st_valid = 1'b0;
        chk(st_err == exp_bad, "R8", "st_err after store", 512'(st_err), 512'(exp_bad));
    endtask

    task automatic do_fence();
        int cyc = 0;
        @(negedge clk);
        fence_req = 1'b1;
        model_fence();
        #1;
        chk(!st_ready, "R7", "st_ready during fence", 512'(st_ready), 512'(0));
        while (!fence_done && cyc < 3000) begin
            @(negedge clk);
            #1;
            cyc++;
            chk(!st_ready, "R7", "st_ready during fence", 512'(st_ready), 512'(0));
        end
        chk(fence_done, "R6", "fence completes", 512'(fence_done), 512'(1));
        chk(q_head == q_tail, "R6", "bursts owed at fence_done", 512'(q_tail - q_head), 512'(0));
        fence_req = 1'b0;
        @(negedge clk);
        #1;
        chk(!fence_done, "R6", "fence_done is one pulse", 512'(fence_done), 512'(0));
    endtask

    function automatic logic [255:0] rnd_data();
        logic [255:0] r;
        for (int k = 0; k < 8; k++) r[k*32 +: 32] = $urandom;
        return r;
    endfunction

    // Backpressure driver, away from the edges
    initial begin
        wr_ready = 1'b0;
        forever begin
            @(posedge clk);
            #2;
            wr_ready = bp_on ? (($urandom % 10) < 7) : 1'b1;
        end
    end

    // Burst monitor
    logic         p_stall = 1'b0;
    logic [31:0]  p_addr;
    logic [63:0]  p_mask;
    logic [511:0] p_data;
    always begin
        @(negedge clk);
        if (rst_n) begin
            if (p_stall) begin
                chk(wr_valid && wr_addr == p_addr && wr_mask == p_mask && wr_data == p_data,
                    "R9", "burst held under backpressure", 512'(wr_addr), 512'(p_addr));
            end
            p_stall = wr_valid && !wr_ready;
            p_addr = wr_addr;
            p_mask = wr_mask;
            p_data = wr_data;
            if (wr_valid && wr_ready) begin
                obs_cnt++;
                if (q_head == q_tail) begin
                    chk(1'b0, "R4", "unexpected burst", 512'(wr_addr), 512'(0));
                end else begin
                    chk(wr_addr == q_addr[q_head], "R5", "burst address order (R6)",
                        512'(wr_addr), 512'(q_addr[q_head]));
                    chk(wr_mask == q_mask[q_head], "R4", "burst mask",
                        512'(wr_mask), 512'(q_mask[q_head]));
                    chk((wr_data & expand(wr_mask)) == (q_data[q_head] & expand(q_mask[q_head])),
                        "R10", "burst data", wr_data, q_data[q_head]);
                    q_head++;
                end
            end
        end else begin
            p_stall = 1'b0;
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    localparam logic [31:0] BASE = 32'h0001_0000;

    initial begin
        int pre;
        void'($urandom(32'd2024));
        for (int i = 0; i < 4; i++) begin
            m_valid[i] = 1'b0;
            m_tag[i] = '0;
            m_data[i] = '0;
            m_mask[i] = '0;
            m_seq[i] = 0;
        end
        rst_n = 1'b0;
        st_valid = 1'b0;
        st_addr = '0;
        st_size = '0;
        st_be = '0;
        st_data = '0;
        fence_req = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        // R1 reset state
        chk(!wr_valid, "R1", "wr_valid after reset", 512'(wr_valid), 512'(0));
        chk(st_ready, "R1", "st_ready after reset", 512'(st_ready), 512'(1));
        chk(!fence_done, "R1", "fence_done after reset", 512'(fence_done), 512'(0));
        chk(!st_err, "R1", "st_err after reset", 512'(st_err), 512'(0));

        // R2 R3: two 32-byte halves fill a line, sent without a fence
        pre = obs_cnt;
        do_store(BASE, 2'd2, 32'hFFFF_FFFF, rnd_data());
        do_store(BASE + 32, 2'd2, 32'hFFFF_FFFF, rnd_data());
        repeat (6) @(negedge clk);
        chk(obs_cnt == pre + 1, "R2", "one burst for merged line", 512'(obs_cnt - pre), 512'(1));
        chk(q_head == q_tail, "R3", "full line sent without fence", 512'(q_tail - q_head), 512'(0));

        // R4 R10: partial merges, overwrite and offset placement held until fence
        pre = obs_cnt;
        do_store(BASE + 64 + 8, 2'd0, 32'h0000_000F, rnd_data());
        do_store(BASE + 64 + 8, 2'd0, 32'h0000_00FF, rnd_data());
        do_store(BASE + 64 + 48, 2'd1, 32'h0000_F0F0, rnd_data());
        repeat (6) @(negedge clk);
        chk(obs_cnt == pre, "R4", "partial line held", 512'(obs_cnt - pre), 512'(0));
        do_fence();
        chk(obs_cnt == pre + 1, "R10", "partial line sent on fence", 512'(obs_cnt - pre), 512'(1));

        // R5: five regions into four buffers evict the oldest
        pre = obs_cnt;
        for (int k = 0; k < 5; k++) do_store(BASE + 32'(k * 64 + 128), 2'd0, 32'hFF, rnd_data());
        repeat (6) @(negedge clk);
        chk(obs_cnt == pre + 1, "R5", "one eviction", 512'(obs_cnt - pre), 512'(1));
        // R6: fence drains the rest oldest first
        do_fence();
        chk(obs_cnt == pre + 5, "R6", "all lines drained", 512'(obs_cnt - pre), 512'(5));

        // R11: fence on empty pool
        pre = obs_cnt;
        do_fence();
        chk(obs_cnt == pre, "R11", "empty fence sends nothing", 512'(obs_cnt - pre), 512'(0));

        // R8: misaligned and bad size code are ignored
        pre = obs_cnt;
        do_store(BASE + 4, 2'd0, 32'hFF, rnd_data());
        do_store(BASE + 16, 2'd2, 32'hFFFF_FFFF, rnd_data());
        do_store(BASE, 2'd3, 32'hFFFF_FFFF, rnd_data());
        do_fence();
        chk(obs_cnt == pre, "R8", "rejected stores leave no burst", 512'(obs_cnt - pre), 512'(0));

        // Random phase with backpressure
        bp_on = 1'b1;
        for (int n = 0; n < 400; n++) begin
            logic [1:0]  sz = 2'($urandom % 3);
            int          nb = 8 << sz;
            logic [31:0] a = BASE + 32'(($urandom % 6) * 64) + 32'(($urandom % (64 / nb)) * nb);
            logic [31:0] be = (($urandom % 2) == 0) ? 32'hFFFF_FFFF : $urandom;
            if (($urandom % 12) == 0) a = a + 32'd4;
            if (($urandom % 40) == 0) sz = 2'd3;
            do_store(a, sz, be, rnd_data());
            if ((n % 60) == 59) do_fence();
        end
        do_fence();
        bp_on = 1'b0;
        repeat (4) @(negedge clk);
        chk(q_head == q_tail, "R4", "no burst left owed", 512'(q_tail - q_head), 512'(0));

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule